// File: doc/BRIEF.md
# PHY Register Access Controller

This block is a single 32-bit control and status word through which software reaches the registers of an attached serial-bus PHY. Software writes a command that holds a target address, a write data byte and a read or a write strobe. The block turns the command into a serial link request. It shifts the request out on one output line, one bit per clock. The strobe stays set until the last bit of the request has left, and software polls it to learn when the link is free again.

Register values that the PHY sends back arrive on a separate valid/address/data input. That input is independent of the strobes. Each arrival latches the address and the value into the returned fields, sets a done flag and raises a sticky interrupt event. Software clears the interrupt event through a write-one-to-clear input. Only one access may be in flight at a time. Host writes made while a request is still being shifted have no effect.

Top module: `phy_reg_access`

## Requirements
- R1: The read word places the done flag at bit 31, the returned address at bits 27:24, the returned data at 23:16, the read strobe at 15, the write strobe at 14, the target address at 11:8 and the write data at 7:0. Bits 30:28 and 13:12 always read 0.
- R2: After reset, both strobes, the done flag, the interrupt event and the link-request line are 0.
- R3: A host write with bit 15 set, accepted at clock edge E0, drives a 17-bit frame MSB first on the request line, one bit per clock. Bit k of the frame is visible after edge E0+k, for k = 0 to 16. The frame is: a start bit of 1, request type 3'b100, the 4-bit address, 8'h00 and a stop bit of 0.
- R4: A host write with bit 14 set (and bit 15 clear) sends the same frame shape with request type 3'b101 and the written data byte in place of 8'h00.
- R5: The strobe that started a request reads 1 through edge E0+16 and reads 0 after edge E0+17. The request line is 0 whenever no strobe is set.
- R6: Accepting a command with either strobe clears the done flag, unless a PHY value arrives in the same cycle.
- R7: A cycle with the valid input high sets the done flag and latches the address into bits 27:24 and the data into bits 23:16. The result is visible after that clock edge.
- R8: The interrupt event output is set by each arriving value and stays set until the clear input is high. When an arrival and a clear occur in the same cycle, the arrival wins.
- R9: A command with both bit 15 and bit 14 set is treated as a read. Bit 14 reads back 0 and the frame carries type 3'b100 with zero data.
- R10: A host write made while either strobe is set changes no field and starts no request.
- R11: A host write with neither strobe bit set updates only the target address and write data fields. The request line stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Host write enable for the command word |
| csr_wdata | input | 32 | Host write data |
| csr_rdata | output | 32 | Current register word |
| lreq | output | 1 | Serial link-request line, idles low |
| phy_rsp_valid | input | 1 | A PHY register value is present |
| phy_rsp_addr | input | 4 | Address of the returned PHY register |
| phy_rsp_data | input | 8 | Contents of the returned PHY register |
| irq_clr | input | 1 | Clears the interrupt event |
| irq_rcvd | output | 1 | Sticky register-received interrupt event |

## Verification
A stuck or mis-set strobe shows up in the register read word within one cycle of the accepting write. A miscounted shifter appears as an early or late clear of the strobe around edge E0+17, or as a frame whose bits are shifted against the expected start, type, address, data and stop sequence. A capture fault appears one cycle after the valid input, as a wrong returned field, a missing done flag or a missing interrupt event. A failure to ignore writes while busy is seen as a changed target address or a second request straight after the first.

// File: rtl/phy_acc_pkg.sv
package phy_acc_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int TYPE_W  = 3;
  localparam int WORD_W  = 32;
  localparam int FRAME_W = 1 + TYPE_W + ADDR_W + DATA_W + 1;

  // bit positions in the host-visible word
  localparam int POS_DONE  = 31;
  localparam int POS_RADDR = 24;
  localparam int POS_RDATA = 16;
  localparam int POS_RDSTB = 15;
  localparam int POS_WRSTB = 14;
  localparam int POS_TADDR = 8;
  localparam int POS_WDATA = 0;

  typedef enum logic [TYPE_W-1:0] {
    REQ_REG_RD = 3'd4,
    REQ_REG_WR = 3'd5
  } req_kind_e;

  function automatic logic [FRAME_W-1:0] build_frame(
    input req_kind_e          kind,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  data
  );
    return {1'b1, kind, addr, data, 1'b0};
  endfunction
endpackage

// File: rtl/phy_acc_req_shifter.sv
module phy_acc_req_shifter #(
  parameter int FRAME_W = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               lreq_o,
  output logic               active_o,
  output logic               sent_o
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      lreq_o   <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
    end else if (load && !active_o) begin
      lreq_o   <= frame_i[FRAME_W-1];
      sh       <= frame_i << 1;
      cnt      <= CNT_W'(FRAME_W - 1);
      active_o <= 1'b1;
    end else if (active_o) begin
      if (cnt == '0) begin
        active_o <= 1'b0;
        lreq_o   <= 1'b0;
      end else begin
        lreq_o <= sh[FRAME_W-1];
        sh     <= sh << 1;
        cnt    <= cnt - 1'b1;
      end
    end
  end

  assign sent_o = active_o && (cnt == '0);

  // every request begins with a start bit of 1
  assert_start_bit_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> lreq_o);

  // the line returns low once the frame is complete
  assert_idle_after_R5: assert property (@(posedge clk) disable iff (rst)
    sent_o |=> !lreq_o);
endmodule

// File: rtl/phy_acc_rsp_capture.sv
module phy_acc_rsp_capture #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_done,
  input  logic              rsp_valid,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              irq_clr,
  output logic              done_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  // returned fields carry no reset
  always_ff @(posedge clk) begin
    if (rsp_valid) begin
      raddr_o <= rsp_addr;
      rdata_o <= rsp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (rsp_valid)     done_o <= 1'b1;
      else if (clr_done) done_o <= 1'b0;
      if (rsp_valid)     irq_o  <= 1'b1;
      else if (irq_clr)  irq_o  <= 1'b0;
    end
  end

  assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (done_o && raddr_o == $past(rsp_addr) && rdata_o == $past(rsp_data)));

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> irq_o);

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr) |=> irq_o);
endmodule

// File: rtl/phy_reg_access.sv
module phy_reg_access
  import phy_acc_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                csr_wr,
  input  logic [WORD_W-1:0]   csr_wdata,
  output logic [WORD_W-1:0]   csr_rdata,
  output logic                lreq,
  input  logic                phy_rsp_valid,
  input  logic [ADDR_W-1:0]   phy_rsp_addr,
  input  logic [DATA_W-1:0]   phy_rsp_data,
  input  logic                irq_clr,
  output logic                irq_rcvd
);
  logic              rd_stb, wr_stb;
  logic [ADDR_W-1:0] tgt_addr;
  logic [DATA_W-1:0] tgt_data;
  logic              busy, accept, cmd_rd, cmd_wr, start;
  logic              sh_active, sh_sent;
  logic              done;
  logic [ADDR_W-1:0] ret_addr;
  logic [DATA_W-1:0] ret_data;
  logic [FRAME_W-1:0] frame;
  logic [ADDR_W-1:0] in_addr;
  logic [DATA_W-1:0] in_data;
  logic              unused_bits;

  assign busy    = rd_stb | wr_stb;
  assign accept  = csr_wr && !busy;
  assign cmd_rd  = csr_wdata[POS_RDSTB];
  assign cmd_wr  = csr_wdata[POS_WRSTB] && !csr_wdata[POS_RDSTB];
  assign start   = accept && (cmd_rd || cmd_wr);
  assign in_addr = csr_wdata[POS_TADDR +: ADDR_W];
  assign in_data = csr_wdata[POS_WDATA +: DATA_W];
  assign unused_bits = ^{csr_wdata[WORD_W-1:POS_RDSTB+1], csr_wdata[POS_WRSTB-1:POS_TADDR+ADDR_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
    end else if (accept) begin
      rd_stb <= cmd_rd;
      wr_stb <= cmd_wr;
    end else if (sh_sent) begin
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      tgt_addr <= in_addr;
      tgt_data <= in_data;
    end
  end

  always_comb begin
    if (cmd_rd) frame = build_frame(REQ_REG_RD, in_addr, '0);
    else        frame = build_frame(REQ_REG_WR, in_addr, in_data);
  end

  phy_acc_req_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .frame_i  (frame),
    .lreq_o   (lreq),
    .active_o (sh_active),
    .sent_o   (sh_sent)
  );

  phy_acc_rsp_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .clr_done  (start),
    .rsp_valid (phy_rsp_valid),
    .rsp_addr  (phy_rsp_addr),
    .rsp_data  (phy_rsp_data),
    .irq_clr   (irq_clr),
    .done_o    (done),
    .raddr_o   (ret_addr),
    .rdata_o   (ret_data),
    .irq_o     (irq_rcvd)
  );

  always_comb begin
    csr_rdata = '0;
    csr_rdata[POS_DONE]               = done;
    csr_rdata[POS_RADDR +: ADDR_W]    = ret_addr;
    csr_rdata[POS_RDATA +: DATA_W]    = ret_data;
    csr_rdata[POS_RDSTB]              = rd_stb;
    csr_rdata[POS_WRSTB]              = wr_stb;
    csr_rdata[POS_TADDR +: ADDR_W]    = tgt_addr;
    csr_rdata[POS_WDATA +: DATA_W]    = tgt_data;
  end

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && wr_stb));

  assert_line_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !lreq);

  assert_shift_tracks_R5: assert property (@(posedge clk) disable iff (rst)
    busy == sh_active);

  assert_done_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && !busy && (csr_wdata[POS_RDSTB] || csr_wdata[POS_WRSTB]) && !phy_rsp_valid) |=> !done);

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && busy) |=> ($stable(tgt_addr) && $stable(tgt_data)));
endmodule

// File: tb/tb_phy_reg_access.sv
module tb_phy_reg_access;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        lreq;
  logic        phy_rsp_valid = 1'b0;
  logic [3:0]  phy_rsp_addr = '0;
  logic [7:0]  phy_rsp_data = '0;
  logic        irq_clr = 1'b0;
  logic        irq_rcvd;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  phy_reg_access dut (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .lreq(lreq), .phy_rsp_valid(phy_rsp_valid),
    .phy_rsp_addr(phy_rsp_addr), .phy_rsp_data(phy_rsp_data),
    .irq_clr(irq_clr), .irq_rcvd(irq_rcvd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive a command, capture 17 frame bits; returns strobe state at the stop bit and after
  task automatic send_cmd(input logic [31:0] cmd, output logic [16:0] f,
                          output logic [1:0] stb_last, output logic [1:0] stb_after,
                          output logic lreq_after);
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = cmd;
    @(negedge clk);           // after E0
    csr_wr = 1'b0;
    f[16] = lreq;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      f[i] = lreq;
    end
    stb_last = csr_rdata[15:14];
    @(negedge clk);           // after E0+17
    stb_after = csr_rdata[15:14];
    lreq_after = lreq;
  endtask

  task automatic phy_return(input logic [3:0] a, input logic [7:0] d, input logic clr);
    @(negedge clk);
    phy_rsp_valid = 1'b1; phy_rsp_addr = a; phy_rsp_data = d; irq_clr = clr;
    @(negedge clk);
    phy_rsp_valid = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R2 strobes", {30'd0, csr_rdata[15:14]}, 32'd0);
    chk("R2 done", {31'd0, csr_rdata[31]}, 32'd0);
    chk("R2 irq/lreq", {30'd0, irq_rcvd, lreq}, 32'd0);
    chk("R1 reserved", {27'd0, csr_rdata[30:28], csr_rdata[13:12]}, 32'd0);
  endtask

  task automatic t_response();
    phy_return(4'h9, 8'h3C, 1'b0);
    chk("R7 done", {31'd0, csr_rdata[31]}, 32'd1);
    chk("R7/R1 ret addr", {28'd0, csr_rdata[27:24]}, 32'h9);
    chk("R7/R1 ret data", {24'd0, csr_rdata[23:16]}, 32'h3C);
    chk("R8 irq set", {31'd0, irq_rcvd}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 irq sticky", {31'd0, irq_rcvd}, 32'd1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R8 irq cleared", {31'd0, irq_rcvd}, 32'd0);
    phy_return(4'h2, 8'h11, 1'b1);
    chk("R8 set wins", {31'd0, irq_rcvd}, 32'd1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_read(input logic [3:0] a);
    logic [16:0] f; logic [1:0] sl, sa; logic la;
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = 32'h0000_8000 | (32'(a) << 8) | 32'hA5;
    @(negedge clk);
    csr_wr = 1'b0;
    f[16] = lreq;
    chk("R6 done cleared", {31'd0, csr_rdata[31]}, 32'd0);
    chk("R3 read strobe set", {30'd0, csr_rdata[15:14]}, 32'd2);
    for (int i = 15; i >= 0; i--) begin @(negedge clk); f[i] = lreq; end
    sl = csr_rdata[15:14];
    @(negedge clk); sa = csr_rdata[15:14]; la = lreq;
    chk("R3 read frame", {15'd0, f}, {15'd0, 1'b1, 3'b100, a, 8'h00, 1'b0});
    chk("R5 strobe at stop", {30'd0, sl}, 32'd2);
    chk("R5 strobe cleared", {30'd0, sa}, 32'd0);
    chk("R5 line idle", {31'd0, la}, 32'd0);
  endtask

  task automatic t_write(input logic [3:0] a, input logic [7:0] d);
    logic [16:0] f; logic [1:0] sl, sa; logic la;
    send_cmd(32'h0000_4000 | (32'(a) << 8) | 32'(d), f, sl, sa, la);
    chk("R4 write frame", {15'd0, f}, {15'd0, 1'b1, 3'b101, a, d, 1'b0});
    chk("R5 write strobe at stop", {30'd0, sl}, 32'd1);
    chk("R5 write strobe cleared", {30'd0, sa}, 32'd0);
    chk("R1 target fields", {20'd0, csr_rdata[11:0]}, {20'd0, a, d});
  endtask

  task automatic t_both();
    logic [16:0] f; logic [1:0] sl, sa; logic la;
    send_cmd(32'h0000_C000 | 32'h0000_0E77, f, sl, sa, la);
    chk("R9 both->read frame", {15'd0, f}, {15'd0, 1'b1, 3'b100, 4'hE, 8'h00, 1'b0});
    chk("R9 only read strobe", {30'd0, sl}, 32'd2);
  endtask

  task automatic t_busy();
    logic [16:0] f; logic [1:0] sa; logic la;
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = 32'h0000_4000 | 32'h0000_0312;
    @(negedge clk);
    csr_wdata = 32'h0000_8000 | 32'h0000_0BFF;   // stays high while busy
    f[16] = lreq;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); f[i] = lreq;
      if (i == 8) csr_wr = 1'b0;
    end
    chk("R10 fields kept", {20'd0, csr_rdata[11:0]}, 32'h0000_0312);
    chk("R10 frame unchanged", {15'd0, f}, {15'd0, 1'b1, 3'b101, 4'h3, 8'h12, 1'b0});
    @(negedge clk); sa = csr_rdata[15:14]; la = lreq;
    repeat (3) @(negedge clk);
    chk("R10 no second request", {29'd0, csr_rdata[15:14], lreq}, 32'd0);
    chk("R5 after busy", {29'd0, sa, la}, 32'd0);
  endtask

  task automatic t_nostrobe();
    logic seen = 1'b0;
    @(negedge clk);
    csr_wr = 1'b1; csr_wdata = 32'h0000_0D6B;
    @(negedge clk);
    csr_wr = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (lreq) seen = 1'b1;
      @(negedge clk);
    end
    chk("R11 fields updated", {20'd0, csr_rdata[11:0]}, 32'h0000_0D6B);
    chk("R11 no strobe", {30'd0, csr_rdata[15:14]}, 32'd0);
    chk("R11 line quiet", {31'd0, seen}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_response();
    t_read(4'h5);
    t_write(4'hA, 8'hC3);
    t_write(4'h1, 8'h80);
    t_both();
    t_busy();
    t_nostrobe();
    phy_return(4'h7, 8'hE1, 1'b0);
    chk("R7 second capture", {24'd0, csr_rdata[31:24]}, 32'h0000_0087);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule